// File: doc/BRIEF.md
# Byte ALU with Condition-Code and Carry Flag Update

This block is the combinational datapath of a small 8-bit processor core. It takes two operands, an operation code and the current flag state. From these it produces a result byte, a write-enable that tells the register file whether the result should be stored, and the next values of the two-bit condition code, the carry, the half-byte carry and the overflow flag. Every flag an operation does not touch is passed through from its input unchanged. The sequencer can therefore latch all flag outputs on every instruction.

Two mode bits shape the arithmetic. The with-carry bit decides whether the stored carry takes part in add and subtract. It also decides whether the rotates pass through the carry. The compare-mode bit selects between signed and unsigned comparison. Subtraction adds the inverted subtrahend. The decimal-adjust operation corrects a packed BCD byte after an add or subtract, based on which carries are clear.

Top module: `alu_core`

## Requirements
- R1: Operation codes on `op_i` are 0 pass, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract, 6 compare, 7 rotate right, 8 rotate left, 9 decimal adjust, 10 mask test. Pass puts `b_i` on the result and asserts `res_we_o`.
- R2: Any operation that derives the condition code from its result gives 2'b00 for a zero result, 2'b10 when bit 7 is set, and 2'b01 otherwise. The value 2'b11 never appears on `cc_o`.
- R3: AND, OR and XOR combine `a_i` with `b_i` bitwise and assert `res_we_o`. Pass and the logical operations leave carry, half carry and overflow at their input values.
- R4: Add computes `a_i + b_i`, plus `carry_i` only when `wc_i` is 1. Carry-out goes to `carry_o`, and the carry from bit 3 into bit 4 goes to `idc_o`.
- R5: For add and subtract, `ovf_o` is 1 exactly when the two addends share a sign and the result's bit 7 differs from it. For subtract, the second addend is the inverted `b_i`.
- R6: Subtract computes `a_i + ~b_i + 1` when `wc_i` is 0, and `a_i + ~b_i + carry_i` when `wc_i` is 1. Carry-out and half carry are taken from that sum.
- R7: Compare drives `cc_o` to 01 when `a_i` > `b_i`, 00 when they are equal and 10 when `a_i` is less. The comparison is signed when `com_i` is 0 and unsigned when it is 1. `res_we_o` is 0, and carry, half carry and overflow pass through.
- R8: Rotate right with `wc_i` 0 moves bit 0 into bit 7 and keeps carry and half carry. With `wc_i` 1, old carry enters bit 7, old bit 0 becomes carry, and half carry takes old bit 6.
- R9: Rotate left with `wc_i` 0 moves bit 7 into bit 0 and keeps carry and half carry. With `wc_i` 1, old carry enters bit 0, old bit 7 becomes carry, and half carry takes old bit 4.
- R10: Both rotates assert `res_we_o`, set `cc_o` from the rotated value and leave overflow unchanged.
- R11: Decimal adjust adds 8'hA0 when `carry_i` is 0 and 8'h0A when `idc_i` is 0 (8'hAA when both are 0). It asserts `res_we_o` and changes no flag, including the condition code.
- R12: Mask test drives `cc_o` to 00 when every bit set in `b_i` is also set in `a_i`, and to 10 otherwise. It deasserts `res_we_o` and passes the other flags through.
- R13: Codes 11 to 15 deassert `res_we_o` and pass all four flags and the condition code through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Register operand, minuend, first compare operand |
| b_i | input | 8 | Second operand, subtrahend, mask |
| carry_i | input | 1 | Current carry flag |
| idc_i | input | 1 | Current half-byte carry flag |
| ovf_i | input | 1 | Current overflow flag |
| cc_i | input | 2 | Current condition code |
| wc_i | input | 1 | With-carry mode |
| com_i | input | 1 | Compare mode, 1 = unsigned |
| result_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result is meant for a register write |
| cc_o | output | 2 | Next condition code |
| carry_o | output | 1 | Next carry flag |
| idc_o | output | 1 | Next half-byte carry flag |
| ovf_o | output | 1 | Next overflow flag |

## Verification
The bench drives add and subtract with the stored carry set but the with-carry bit clear, and the reverse. A design that always used the carry, or that used it inverted for subtract, is off by one in those cases. Compare is run on 8'h80 against 8'h01 and on 8'h05 against 8'hFB in both modes, so a compare that ignores the mode bit gets one of each pair backwards. The carry-through rotates use operands whose low and high half-bit positions differ, which catches half carry taken from the wrong bit. Decimal adjust and the reserved codes are driven with all flags preset, which exposes any flag or condition-code update that should not happen.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

   typedef enum logic [3:0] {
      OP_PASS = 4'd0,
      OP_AND  = 4'd1,
      OP_OR   = 4'd2,
      OP_XOR  = 4'd3,
      OP_ADD  = 4'd4,
      OP_SUB  = 4'd5,
      OP_CMP  = 4'd6,
      OP_ROR  = 4'd7,
      OP_ROL  = 4'd8,
      OP_DADJ = 4'd9,
      OP_MASK = 4'd10
   } alu_op_e;

   localparam logic [1:0] CC_ZERO = 2'b00;
   localparam logic [1:0] CC_POS  = 2'b01;
   localparam logic [1:0] CC_NEG  = 2'b10;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             wc_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             half_o,
   output logic             ovf_o
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] opb;
   logic             cin;

   assign opb = sub_i ? ~b_i : b_i;
   assign cin = wc_i ? carry_i : sub_i;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar k = 0; k < WIDTH; k++) begin : g_bit
            assign sum_o[k]   = a_i[k] ^ opb[k] ^ chain[k];
            assign chain[k+1] = (a_i[k] & opb[k]) | (chain[k] & (a_i[k] ^ opb[k]));
         end
         assign cout_o = chain[WIDTH];
         assign half_o = chain[HALF];
      end else begin : g_split
         logic [HALF:0]       lo_sum;
         logic [WIDTH-HALF:0] hi_sum;
         assign lo_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, opb[HALF-1:0]} + {{HALF{1'b0}}, cin};
         assign hi_sum = {1'b0, a_i[WIDTH-1:HALF]} + {1'b0, opb[WIDTH-1:HALF]}
                       + {{(WIDTH-HALF){1'b0}}, lo_sum[HALF]};
         assign sum_o  = {hi_sum[WIDTH-HALF-1:0], lo_sum[HALF-1:0]};
         assign cout_o = hi_sum[WIDTH-HALF];
         assign half_o = lo_sum[HALF];
      end
   endgenerate

   assign ovf_o = (a_i[WIDTH-1] == opb[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
   import alu_core_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   input  logic             idc_i,
   input  logic             wc_i,
   output logic [WIDTH-1:0] value_o,
   output logic             carry_o,
   output logic             idc_o
);
   localparam int HALF = WIDTH / 2;
   localparam logic [WIDTH-1:0] ADJ_LO = WIDTH'(4'hA);
   localparam logic [WIDTH-1:0] ADJ_HI = WIDTH'(4'hA) << HALF;

   logic [WIDTH-1:0] adj;

   assign adj = (carry_i ? '0 : ADJ_HI) | (idc_i ? '0 : ADJ_LO);

   always_comb begin
      value_o = a_i;
      carry_o = carry_i;
      idc_o   = idc_i;
      unique case (op_i)
         OP_AND:  value_o = a_i & b_i;
         OP_OR:   value_o = a_i | b_i;
         OP_XOR:  value_o = a_i ^ b_i;
         OP_ROR: begin
            if (wc_i) begin
               value_o = {carry_i, a_i[WIDTH-1:1]};
               carry_o = a_i[0];
               idc_o   = a_i[WIDTH-2];
            end else begin
               value_o = {a_i[0], a_i[WIDTH-1:1]};
            end
         end
         OP_ROL: begin
            if (wc_i) begin
               value_o = {a_i[WIDTH-2:0], carry_i};
               carry_o = a_i[WIDTH-1];
               idc_o   = a_i[HALF];
            end else begin
               value_o = {a_i[WIDTH-2:0], a_i[WIDTH-1]};
            end
         end
         OP_DADJ: value_o = a_i + adj;
         default: value_o = a_i;
      endcase
   end

endmodule

// File: rtl/alu_cond.sv
module alu_cond
   import alu_core_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             com_i,
   output logic [1:0]       res_cc_o,
   output logic [1:0]       cmp_cc_o,
   output logic [1:0]       mask_cc_o
);
   logic gt;
   logic eq;

   assign eq = (a_i == b_i);
   assign gt = com_i ? (a_i > b_i) : ($signed(a_i) > $signed(b_i));

   assign res_cc_o  = (res_i == '0)      ? CC_ZERO :
                      res_i[WIDTH-1]     ? CC_NEG  : CC_POS;
   assign cmp_cc_o  = eq ? CC_ZERO : (gt ? CC_POS : CC_NEG);
   assign mask_cc_o = ((a_i & b_i) == b_i) ? CC_ZERO : CC_NEG;

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_core_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   input  logic             idc_i,
   input  logic             ovf_i,
   input  logic [1:0]       cc_i,
   input  logic             wc_i,
   input  logic             com_i,
   output logic [WIDTH-1:0] result_o,
   output logic             res_we_o,
   output logic [1:0]       cc_o,
   output logic             carry_o,
   output logic             idc_o,
   output logic             ovf_o
);
   generate
      if (WIDTH < 8 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu_core: WIDTH must be even and at least 8");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] as_sum;
   logic             as_cout, as_half, as_ovf;
   logic [WIDTH-1:0] sl_value;
   logic             sl_carry, sl_idc;
   logic [1:0]       res_cc, cmp_cc, mask_cc;

   assign op = alu_op_e'(op_i);

   alu_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_addsub (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (op == OP_SUB),
      .wc_i    (wc_i),
      .carry_i (carry_i),
      .sum_o   (as_sum),
      .cout_o  (as_cout),
      .half_o  (as_half),
      .ovf_o   (as_ovf)
   );

   alu_shift_logic #(.WIDTH(WIDTH)) u_shift_logic (
      .op_i    (op),
      .a_i     (a_i),
      .b_i     (b_i),
      .carry_i (carry_i),
      .idc_i   (idc_i),
      .wc_i    (wc_i),
      .value_o (sl_value),
      .carry_o (sl_carry),
      .idc_o   (sl_idc)
   );

   always_comb begin
      result_o = a_i;
      res_we_o = 1'b0;
      unique case (op)
         OP_PASS: begin
            result_o = b_i;
            res_we_o = 1'b1;
         end
         OP_ADD, OP_SUB: begin
            result_o = as_sum;
            res_we_o = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR, OP_ROR, OP_ROL, OP_DADJ: begin
            result_o = sl_value;
            res_we_o = 1'b1;
         end
         default: begin
            result_o = a_i;
            res_we_o = 1'b0;
         end
      endcase
   end

   alu_cond #(.WIDTH(WIDTH)) u_cond (
      .res_i     (result_o),
      .a_i       (a_i),
      .b_i       (b_i),
      .com_i     (com_i),
      .res_cc_o  (res_cc),
      .cmp_cc_o  (cmp_cc),
      .mask_cc_o (mask_cc)
   );

   always_comb begin
      cc_o    = cc_i;
      carry_o = carry_i;
      idc_o   = idc_i;
      ovf_o   = ovf_i;
      unique case (op)
         OP_PASS, OP_AND, OP_OR, OP_XOR: cc_o = res_cc;
         OP_ADD, OP_SUB: begin
            cc_o    = res_cc;
            carry_o = as_cout;
            idc_o   = as_half;
            ovf_o   = as_ovf;
         end
         OP_ROR, OP_ROL: begin
            cc_o    = res_cc;
            carry_o = sl_carry;
            idc_o   = sl_idc;
         end
         OP_CMP:  cc_o = cmp_cc;
         OP_MASK: cc_o = mask_cc;
         default: cc_o = cc_i;
      endcase
   end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int WIDTH = 8
) (
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             carry_i,
   input logic             idc_i,
   input logic             ovf_i,
   input logic [1:0]       cc_i,
   input logic             wc_i,
   input logic [WIDTH-1:0] result_o,
   input logic             res_we_o,
   input logic [1:0]       cc_o,
   input logic             carry_o,
   input logic             idc_o,
   input logic             ovf_o
);
   logic known;
   assign known = !$isunknown({op_i, a_i, b_i, carry_i, idc_i, ovf_i, cc_i, wc_i});

   always_comb begin
      if (known) begin
         AST_CC_LEGAL: assert (cc_o != 2'b11); // R2
         if (op_i == 4'd6) begin
            AST_CMP_SIDE_EFFECTS: assert (!res_we_o && carry_o == carry_i && idc_o == idc_i && ovf_o == ovf_i); // R7
         end
         if (op_i >= 4'd1 && op_i <= 4'd3) begin
            AST_LOGIC_KEEPS_FLAGS: assert (res_we_o && carry_o == carry_i && idc_o == idc_i && ovf_o == ovf_i); // R3
         end
         if (op_i == 4'd4) begin
            AST_ADD_OVF_SIGNS: assert (!ovf_o || (a_i[WIDTH-1] == b_i[WIDTH-1] && result_o[WIDTH-1] != a_i[WIDTH-1])); // R5
         end
         if (op_i == 4'd9) begin
            AST_DADJ_NO_FLAGS: assert (cc_o == cc_i && carry_o == carry_i && idc_o == idc_i && ovf_o == ovf_i); // R11
         end
         if ((op_i == 4'd7 || op_i == 4'd8) && !wc_i) begin
            AST_PLAIN_ROT_KEEPS: assert (carry_o == carry_i && idc_o == idc_i && $countones(result_o) == $countones(a_i)); // R8
         end
         if (op_i >= 4'd11) begin
            AST_RESERVED_IDLE: assert (!res_we_o && cc_o == cc_i && carry_o == carry_i && idc_o == idc_i && ovf_o == ovf_i); // R13
         end
      end
   end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_alu_core_chk (
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .carry_i  (carry_i),
   .idc_i    (idc_i),
   .ovf_i    (ovf_i),
   .cc_i     (cc_i),
   .wc_i     (wc_i),
   .result_o (result_o),
   .res_we_o (res_we_o),
   .cc_o     (cc_o),
   .carry_o  (carry_o),
   .idc_o    (idc_o),
   .ovf_o    (ovf_o)
);

// File: tb/test_alu_core.sv
module test_alu_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] op;
   logic [7:0] a, b;
   logic       c_in, h_in, v_in, wc, com;
   logic [1:0] cc_in;
   logic [7:0] res;
   logic       we, c_out, h_out, v_out;
   logic [1:0] cc_out;
   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   alu_core i_alu_core (
      .op_i (op), .a_i (a), .b_i (b),
      .carry_i (c_in), .idc_i (h_in), .ovf_i (v_in), .cc_i (cc_in),
      .wc_i (wc), .com_i (com),
      .result_o (res), .res_we_o (we), .cc_o (cc_out),
      .carry_o (c_out), .idc_o (h_out), .ovf_o (v_out)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic c, input logic h, input logic v, input logic [1:0] cc,
                        input logic w, input logic m);
      @(negedge clk);
      op = o; a = x; b = y; c_in = c; h_in = h; v_in = v; cc_in = cc; wc = w; com = m;
      #3;
   endtask

   task automatic expect_all(input string req, input logic [7:0] r, input logic e_we,
                             input logic [1:0] e_cc, input logic e_c, input logic e_h, input logic e_v);
      chk(req, "result", res, r);
      chk(req, "we", we, e_we);
      chk(req, "cc", cc_out, e_cc);
      chk(req, "carry", c_out, e_c);
      chk(req, "idc", h_out, e_h);
      chk(req, "ovf", v_out, e_v);
   endtask

   task automatic t_reset_pass;
      drive(4'd0, 8'h00, 8'h00, 0, 0, 0, 2'b01, 0, 0);
      expect_all("R1", 8'h00, 1, 2'b00, 0, 0, 0);
      drive(4'd0, 8'h11, 8'h7F, 1, 1, 1, 2'b10, 0, 0);
      expect_all("R1", 8'h7F, 1, 2'b01, 1, 1, 1);
      drive(4'd0, 8'h11, 8'h80, 0, 0, 0, 2'b00, 0, 0);
      expect_all("R2", 8'h80, 1, 2'b10, 0, 0, 0);
   endtask

   task automatic t_logic;
      drive(4'd1, 8'hF0, 8'h3C, 1, 1, 1, 2'b00, 0, 0);
      expect_all("R3", 8'h30, 1, 2'b01, 1, 1, 1);
      drive(4'd2, 8'h0F, 8'h80, 1, 0, 1, 2'b00, 0, 0);
      expect_all("R3", 8'h8F, 1, 2'b10, 1, 0, 1);
      drive(4'd3, 8'h5A, 8'h5A, 0, 1, 0, 2'b01, 1, 1);
      expect_all("R3", 8'h00, 1, 2'b00, 0, 1, 0);
   endtask

   task automatic t_add;
      drive(4'd4, 8'h3C, 8'h47, 0, 0, 0, 2'b00, 0, 0);
      expect_all("R5", 8'h83, 1, 2'b10, 0, 1, 1);
      drive(4'd4, 8'hFF, 8'h00, 1, 0, 1, 2'b01, 1, 0);
      expect_all("R4", 8'h00, 1, 2'b00, 1, 1, 0);
      drive(4'd4, 8'hFF, 8'h00, 1, 1, 1, 2'b01, 0, 0);
      expect_all("R4", 8'hFF, 1, 2'b10, 0, 0, 0);
      for (int i = 0; i < 16; i++) begin
         logic [7:0] x, y;
         logic [8:0] s;
         x = 8'(i * 37 + 5); y = 8'(i * 91 + 60);
         s = {1'b0, x} + {1'b0, y} + 9'(i[0]);
         drive(4'd4, x, y, i[0], 0, 0, 2'b00, 1, 0);
         chk("R4", "sweep sum", res, s[7:0]);
         chk("R4", "sweep carry", c_out, s[8]);
         chk("R4", "sweep idc", h_out, (5'(x[3:0]) + 5'(y[3:0]) + 5'(i[0])) >= 5'd16);
      end
   endtask

   task automatic t_sub;
      drive(4'd5, 8'h50, 8'h20, 0, 0, 1, 2'b00, 0, 0);
      expect_all("R6", 8'h30, 1, 2'b01, 1, 1, 0);
      drive(4'd5, 8'h50, 8'h20, 0, 1, 0, 2'b00, 1, 0);
      expect_all("R6", 8'h2F, 1, 2'b01, 1, 0, 0);
      drive(4'd5, 8'h80, 8'h01, 0, 1, 0, 2'b00, 0, 0);
      expect_all("R5", 8'h7F, 1, 2'b01, 1, 0, 1);
      drive(4'd5, 8'h10, 8'h20, 1, 0, 1, 2'b00, 0, 0);
      expect_all("R6", 8'hF0, 1, 2'b10, 0, 1, 0);
   endtask

   task automatic t_compare;
      drive(4'd6, 8'h80, 8'h01, 1, 0, 1, 2'b11, 0, 0);
      chk("R7", "signed 80<01", cc_out, 2'b10);
      chk("R7", "no write", we, 0);
      chk("R7", "carry kept", c_out, 1);
      drive(4'd6, 8'h80, 8'h01, 1, 0, 1, 2'b00, 0, 1);
      chk("R7", "unsigned 80>01", cc_out, 2'b01);
      drive(4'd6, 8'h05, 8'hFB, 0, 1, 0, 2'b00, 0, 0);
      chk("R7", "signed 05>FB", cc_out, 2'b01);
      chk("R7", "idc kept", h_out, 1);
      drive(4'd6, 8'h05, 8'hFB, 0, 1, 0, 2'b00, 0, 1);
      chk("R7", "unsigned 05<FB", cc_out, 2'b10);
      drive(4'd6, 8'h44, 8'h44, 0, 0, 0, 2'b10, 0, 1);
      chk("R7", "equal", cc_out, 2'b00);
   endtask

   task automatic t_rotate;
      drive(4'd7, 8'h01, 8'h00, 0, 1, 1, 2'b00, 0, 0);
      expect_all("R8", 8'h80, 1, 2'b10, 0, 1, 1);
      drive(4'd7, 8'h41, 8'h00, 0, 0, 0, 2'b00, 1, 0);
      expect_all("R8", 8'h20, 1, 2'b01, 1, 1, 0);
      drive(4'd8, 8'h81, 8'h00, 0, 0, 1, 2'b10, 0, 0);
      expect_all("R9", 8'h03, 1, 2'b01, 0, 0, 1);
      drive(4'd8, 8'h10, 8'h00, 1, 0, 0, 2'b00, 1, 0);
      expect_all("R9", 8'h21, 1, 2'b01, 0, 1, 0);
      drive(4'd8, 8'h80, 8'h00, 0, 1, 1, 2'b01, 1, 0);
      expect_all("R10", 8'h00, 1, 2'b00, 1, 0, 1);
   endtask

   task automatic t_dadj;
      drive(4'd9, 8'h00, 8'h00, 0, 0, 1, 2'b01, 0, 0);
      expect_all("R11", 8'hAA, 1, 2'b01, 0, 0, 1);
      drive(4'd9, 8'h00, 8'h00, 1, 0, 0, 2'b10, 0, 0);
      expect_all("R11", 8'h0A, 1, 2'b10, 1, 0, 0);
      drive(4'd9, 8'h00, 8'h00, 0, 1, 0, 2'b00, 1, 0);
      expect_all("R11", 8'hA0, 1, 2'b00, 0, 1, 0);
      drive(4'd9, 8'h38, 8'h00, 1, 1, 1, 2'b01, 0, 0);
      expect_all("R11", 8'h38, 1, 2'b01, 1, 1, 1);
   endtask

   task automatic t_mask;
      drive(4'd10, 8'hF3, 8'h33, 1, 1, 1, 2'b10, 0, 0);
      chk("R12", "all set cc", cc_out, 2'b00);
      chk("R12", "no write", we, 0);
      chk("R12", "ovf kept", v_out, 1);
      drive(4'd10, 8'hF3, 8'h0C, 0, 0, 0, 2'b00, 0, 0);
      chk("R12", "missing cc", cc_out, 2'b10);
      drive(4'd10, 8'h00, 8'h00, 0, 0, 0, 2'b10, 0, 0);
      chk("R12", "empty mask cc", cc_out, 2'b00);
   endtask

   task automatic t_reserved;
      for (int k = 11; k < 16; k++) begin
         drive(4'(k), 8'hC3, 8'h5A, 1, 0, 1, 2'b10, 1, 1);
         chk("R13", "we", we, 0);
         chk("R13", "cc", cc_out, 2'b10);
         chk("R13", "flags", {c_out, h_out, v_out}, 3'b101);
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      op = 4'd0; a = '0; b = '0; c_in = 0; h_in = 0; v_in = 0; cc_in = 2'b00; wc = 0; com = 0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_pass();
      t_logic();
      t_add();
      t_sub();
      t_compare();
      t_rotate();
      t_dadj();
      t_mask();
      t_reserved();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule